// File: doc/BRIEF.md
# Instruction Trace Interrupt Generator

This block sits at the completion stage of a simple in-order 64-bit core. For every instruction that retires, it decides whether a trace interrupt must be raised before the next instruction runs. Each retirement brings four things: the instruction's address, its branch target, its class flags and any higher-priority exception. The block combines these with the single-step and branch-trace enables taken from the machine-state word.

When a trace fires, the block pulses a trap request one cycle after the retirement. In that same cycle it presents the trace vector, a clear mask for both trace enables, and two captured values. The first is the address of the instruction that would have run next. The second is a status word that records what kind of access the traced instruction made. The captured values stay unchanged until the next trace fires. The instruction's own results are committed by the core before the block sees the retirement, so the trap is always taken after the traced instruction has fully finished.

Top module: `trace_irq_gen`

## Requirements
- R1: Out of reset, `trap_o`, `vector_o`, `save_addr_o`, `save_status_o` and `msr_clr_o` are all zero.
- R2: When machine-state bit 10 (value 0x400, single step) is set, every valid retirement that carries no other exception raises `trap_o` for exactly one cycle, on the cycle after the retirement.
- R3: When only machine-state bit 9 (value 0x200, branch trace) is set, a trap is raised only for a retirement with both `is_branch_i` and `br_taken_i` high. A not-taken branch or a non-branch instruction raises no trap.
- R4: `vector_o` reads 0xd00 in the cycle `trap_o` is high and reads zero in every other cycle.
- R5: `save_addr_o` holds `retire_pc_i + 4` for a traced sequential instruction or not-taken branch. It holds `br_target_i` for a traced taken branch.
- R6: For a traced instruction that is neither a load, a store nor a cache touch, `save_status_o` is exactly 0x40000000. Under the mask 0x781f0000, it shows only bit 30.
- R7: A traced load or cache-touch-for-load adds bit 28 (0x10000000), giving 0x50000000. A traced store or cache-touch-for-store adds bit 27 (0x08000000), giving 0x48000000.
- R8: A retirement with `other_exc_i` high never raises a trace trap, whatever the enables are.
- R9: `msr_clr_o` equals 0x600 (bits 10 and 9) in the cycle `trap_o` is high, and is zero in every other cycle.
- R10: When no trap fires, `save_addr_o` and `save_status_o` keep their previous values. Cycles where `retire_valid_i` is low raise no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_valid_i | input | 1 | An instruction retires this cycle |
| retire_pc_i | input | 64 | Address of the retiring instruction |
| br_target_i | input | 64 | Branch target of the retiring instruction |
| is_load_i | input | 1 | Instruction is a load |
| is_store_i | input | 1 | Instruction is a store |
| is_touch_ld_i | input | 1 | Instruction is a cache touch for load |
| is_touch_st_i | input | 1 | Instruction is a cache touch for store |
| is_branch_i | input | 1 | Instruction is a branch |
| br_taken_i | input | 1 | The branch resolved taken |
| other_exc_i | input | 1 | Instruction raised a higher-priority exception |
| msr_i | input | 64 | Current machine-state word |
| trap_o | output | 1 | Trace trap request, one-cycle pulse |
| vector_o | output | 64 | Trap vector while trapping, zero otherwise |
| save_addr_o | output | 64 | Captured address of the next instruction |
| save_status_o | output | 64 | Captured trace status word |
| msr_clr_o | output | 64 | Machine-state bits to clear while trapping |

## Verification
Every result is registered once, so it is due in the cycle right after the retirement. The trap pulse, vector and clear mask last that one cycle only. The captured address and status stay in place until the next trace fires.

The bench drives a retirement on a falling edge and drops `retire_valid_i` on the next falling edge. At that point it samples all outputs, which the rising edge in between has just updated. For pulses, it checks the cycle after that as well, to confirm the pulse has ended. For suppressed cases, it checks that the captured values are still the ones from the previous trace.

// File: rtl/trace_irq_pkg.sv
package trace_irq_pkg;
  localparam int unsigned XLEN         = 64;
  localparam int unsigned STEP_BIT     = 10;
  localparam int unsigned BTRACE_BIT   = 9;
  localparam int unsigned ST_TRACE_BIT = 30;
  localparam int unsigned ST_LOAD_BIT  = 28;
  localparam int unsigned ST_STORE_BIT = 27;
  localparam int unsigned INSN_BYTES   = 4;
  localparam logic [XLEN-1:0] TRACE_VEC = 64'h0000_0000_0000_0d00;

  typedef struct packed {
    logic ld;
    logic st;
  } acc_kind_t;
endpackage

// File: rtl/trace_fire.sv
module trace_fire (
  input  logic valid_i,
  input  logic exc_i,
  input  logic step_en_i,
  input  logic btrace_en_i,
  input  logic is_branch_i,
  input  logic taken_i,
  output logic fire_o,
  output logic redirect_o
);
  assign redirect_o = is_branch_i & taken_i;
  // other exceptions take priority over trace
  assign fire_o = valid_i & ~exc_i & (step_en_i | (btrace_en_i & redirect_o));
endmodule

// File: rtl/trace_status_enc.sv
module trace_status_enc #(
  parameter int unsigned XLEN      = 64,
  parameter int unsigned TRACE_BIT = 30,
  parameter int unsigned LOAD_BIT  = 28,
  parameter int unsigned STORE_BIT = 27
) (
  input  logic            load_i,
  input  logic            store_i,
  input  logic            touch_ld_i,
  input  logic            touch_st_i,
  output logic [XLEN-1:0] status_o
);
  import trace_irq_pkg::*;
  acc_kind_t kind;

  always_comb begin
    kind.ld = load_i | touch_ld_i;
    kind.st = store_i | touch_st_i;
    status_o = '0;
    status_o[TRACE_BIT] = 1'b1;
    status_o[LOAD_BIT]  = kind.ld;
    status_o[STORE_BIT] = kind.st;
  end
endmodule

// File: rtl/trace_capture.sv
module trace_capture #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] status_i,
  input  logic [XLEN-1:0] clr_mask_i,
  output logic            trap_o,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o   <= 1'b0;
      addr_o   <= '0;
      status_o <= '0;
      clr_o    <= '0;
    end else begin
      trap_o <= fire_i;
      clr_o  <= fire_i ? clr_mask_i : '0;
      if (fire_i) begin
        addr_o   <= addr_i;
        status_o <= status_i;
      end
    end
  end
endmodule

// File: rtl/trace_irq_gen.sv
module trace_irq_gen #(
  parameter int unsigned XLEN = trace_irq_pkg::XLEN
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            retire_valid_i,
  input  logic [XLEN-1:0] retire_pc_i,
  input  logic [XLEN-1:0] br_target_i,
  input  logic            is_load_i,
  input  logic            is_store_i,
  input  logic            is_touch_ld_i,
  input  logic            is_touch_st_i,
  input  logic            is_branch_i,
  input  logic            br_taken_i,
  input  logic            other_exc_i,
  input  logic [XLEN-1:0] msr_i,
  output logic            trap_o,
  output logic [XLEN-1:0] vector_o,
  output logic [XLEN-1:0] save_addr_o,
  output logic [XLEN-1:0] save_status_o,
  output logic [XLEN-1:0] msr_clr_o
);
  import trace_irq_pkg::*;

  localparam logic [XLEN-1:0] CLR_MASK = (XLEN'(1) << STEP_BIT) | (XLEN'(1) << BTRACE_BIT);
  localparam logic [XLEN-1:0] STEP_INC = XLEN'(INSN_BYTES);

  logic            fire, redirect;
  logic [XLEN-1:0] next_addr, status;

  trace_fire u_fire (
    .valid_i    (retire_valid_i),
    .exc_i      (other_exc_i),
    .step_en_i  (msr_i[STEP_BIT]),
    .btrace_en_i(msr_i[BTRACE_BIT]),
    .is_branch_i(is_branch_i),
    .taken_i    (br_taken_i),
    .fire_o     (fire),
    .redirect_o (redirect)
  );

  trace_status_enc #(
    .XLEN(XLEN), .TRACE_BIT(ST_TRACE_BIT), .LOAD_BIT(ST_LOAD_BIT), .STORE_BIT(ST_STORE_BIT)
  ) u_status (
    .load_i    (is_load_i),
    .store_i   (is_store_i),
    .touch_ld_i(is_touch_ld_i),
    .touch_st_i(is_touch_st_i),
    .status_o  (status)
  );

  assign next_addr = redirect ? br_target_i : retire_pc_i + STEP_INC;

  trace_capture #(.XLEN(XLEN)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .addr_i    (next_addr),
    .status_i  (status),
    .clr_mask_i(CLR_MASK),
    .trap_o    (trap_o),
    .addr_o    (save_addr_o),
    .status_o  (save_status_o),
    .clr_o     (msr_clr_o)
  );

  assign vector_o = trap_o ? TRACE_VEC[XLEN-1:0] : '0;
endmodule

// File: rtl/trace_irq_gen_chk.sv
module trace_irq_gen_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            retire_valid_i,
  input logic [XLEN-1:0] retire_pc_i,
  input logic [XLEN-1:0] br_target_i,
  input logic            is_load_i,
  input logic            is_store_i,
  input logic            is_touch_ld_i,
  input logic            is_touch_st_i,
  input logic            is_branch_i,
  input logic            br_taken_i,
  input logic            other_exc_i,
  input logic [XLEN-1:0] msr_i,
  input logic            trap_o,
  input logic [XLEN-1:0] vector_o,
  input logic [XLEN-1:0] save_addr_o,
  input logic [XLEN-1:0] save_status_o,
  input logic [XLEN-1:0] msr_clr_o
);
  a_r2_step_traps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_valid_i && msr_i[10] && !other_exc_i) |=> trap_o);

  a_r3_no_untaken_trace: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msr_i[10] && !(is_branch_i && br_taken_i)) |=> !trap_o);

  a_r8_exc_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_valid_i && other_exc_i) |=> !trap_o);

  a_r5_seq_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_valid_i && msr_i[10] && !other_exc_i && !is_branch_i)
      |=> save_addr_o == $past(retire_pc_i) + 64'd4);

  a_r9_clr_only_in_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_clr_o != '0) |-> (trap_o && vector_o != '0));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> ($stable(save_addr_o) && $stable(save_status_o)));

  a_r6_mask_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> ((save_status_o & 64'h2000_0000) == '0 && (save_status_o & 64'h001f_0000) == '0));
endmodule

bind trace_irq_gen trace_irq_gen_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/trace_irq_gen_tb_top.sv
`timescale 1ns/1ps
module trace_irq_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        retire_valid_i = 1'b0;
  logic [63:0] retire_pc_i = '0, br_target_i = '0, msr_i = '0;
  logic        is_load_i = 0, is_store_i = 0, is_touch_ld_i = 0, is_touch_st_i = 0;
  logic        is_branch_i = 0, br_taken_i = 0, other_exc_i = 0;
  logic        trap_o;
  logic [63:0] vector_o, save_addr_o, save_status_o, msr_clr_o;

  int checks = 0, failures = 0;
  bit done = 0;

  localparam logic [63:0] STEP = 64'h400, BT = 64'h200;
  localparam logic [63:0] MASK = 64'h781f_0000;

  always #2.5 clk_i = ~clk_i;

  trace_irq_gen dut_i (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flags: {load, store, tld, tst, branch, taken, exc}
  task automatic retire(logic [63:0] pc, logic [63:0] tgt, logic [6:0] f, logic [63:0] msr);
    @(negedge clk_i);
    retire_valid_i = 1; retire_pc_i = pc; br_target_i = tgt; msr_i = msr;
    {is_load_i, is_store_i, is_touch_ld_i, is_touch_st_i, is_branch_i, br_taken_i, other_exc_i} = f;
    @(negedge clk_i);
    retire_valid_i = 0;
    {is_load_i, is_store_i, is_touch_ld_i, is_touch_st_i, is_branch_i, br_taken_i, other_exc_i} = '0;
  endtask

  task automatic expect_trap(string req, logic [63:0] addr, logic [63:0] st);
    check({req, " trap"}, 64'(trap_o), 64'd1);
    check("R4 vector", vector_o, 64'hd00);
    check("R9 clr", msr_clr_o, 64'h600);
    check({req, " addr"}, save_addr_o, addr);
    check({req, " status"}, save_status_o, st);
    check({req, " masked"}, save_status_o & MASK, st & MASK);
  endtask

  task automatic expect_quiet(string req, logic [63:0] addr, logic [63:0] st);
    check({req, " no trap"}, 64'(trap_o), 64'd0);
    check("R4 vector idle", vector_o, 64'd0);
    check("R9 clr idle", msr_clr_o, 64'd0);
    check("R10 addr held", save_addr_o, addr);
    check("R10 status held", save_status_o, st);
  endtask

  task automatic t_reset;
    check("R1 trap", 64'(trap_o), 0);
    check("R1 vector", vector_o, 0);
    check("R1 addr", save_addr_o, 0);
    check("R1 status", save_status_o, 0);
    check("R1 clr", msr_clr_o, 0);
  endtask

  task automatic t_step_plain;
    retire(64'h1000, 64'h9999, 7'b0, STEP);
    expect_trap("R2 R5 R6", 64'h1004, 64'h4000_0000);
    @(negedge clk_i);
    expect_quiet("R2 pulse end", 64'h1004, 64'h4000_0000);
  endtask

  task automatic t_step_kinds;
    retire(64'h2000, 0, 7'b1000000, STEP);
    expect_trap("R7 load", 64'h2004, 64'h5000_0000);
    retire(64'h2100, 0, 7'b0100000, STEP);
    expect_trap("R7 store", 64'h2104, 64'h4800_0000);
    retire(64'h2200, 0, 7'b0010000, STEP);
    expect_trap("R7 touch ld", 64'h2204, 64'h5000_0000);
    retire(64'h2300, 0, 7'b0001000, STEP);
    expect_trap("R7 touch st", 64'h2304, 64'h4800_0000);
  endtask

  task automatic t_btrace;
    retire(64'h3000, 64'h3040, 7'b0000110, BT);
    expect_trap("R3 R5 taken", 64'h3040, 64'h4000_0000);
    retire(64'h3100, 64'h3180, 7'b0000100, BT);
    expect_quiet("R3 not taken", 64'h3040, 64'h4000_0000);
    retire(64'h3200, 64'h3280, 7'b1000000, BT);
    expect_quiet("R3 non-branch", 64'h3040, 64'h4000_0000);
  endtask

  task automatic t_step_branch;
    retire(64'h4000, 64'h4abc, 7'b0000110, STEP);
    expect_trap("R5 step taken", 64'h4abc, 64'h4000_0000);
    retire(64'h4100, 64'h4abc, 7'b0000100, STEP);
    expect_trap("R5 step untaken", 64'h4104, 64'h4000_0000);
  endtask

  task automatic t_exc;
    retire(64'h5000, 64'h5040, 7'b0000111, STEP | BT);
    expect_quiet("R8 exception", 64'h4104, 64'h4000_0000);
  endtask

  task automatic t_idle;
    @(negedge clk_i);
    msr_i = STEP | BT; retire_valid_i = 0;
    @(negedge clk_i);
    expect_quiet("R10 idle", 64'h4104, 64'h4000_0000);
  endtask

  initial begin
    #1;
    t_reset;
    #20 rst_ni = 1;
    t_reset;
    t_step_plain;
    t_step_kinds;
    t_btrace;
    t_step_branch;
    t_exc;
    t_idle;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule